// File: doc/BRIEF.md
# Residue-to-Binary Converter with Channel Pre-Offset

This block turns a three-channel residue number, taken over the moduli 2^K, 2^N+1 and 2^N-1, back into an ordinary binary integer. It has two parts. The first is a pre-offset stage of two constant adders that lives in the odd residue channels. The second is a converter core whose adder tree holds no constant term.

The correction constant that a plain converter would add inside its adder tree is worked out once, at elaboration. It is then injected into the odd channels as two residues. The channel mod 2^N+1 adds (2^K·C1) mod (2^N+1). The channel mod 2^N-1 adds (2^K·C1) mod (2^N-1). The even residue passes through untouched, because 2^K·C1 is a multiple of 2^K.

The core forms three operands from the offset residues and sums them modulo 2^{2N}-1. It uses one carry-save layer with end-around carry, followed by a canonical two-operand end-around adder. The result V is placed above x1 to give X = V·2^K + x1. One conversion enters every cycle, and the latency is two cycles.

Parameters N (2 to 16) and K (2 to 2N) set the channel widths. The output is K+2N bits wide. The inputs are expected as canonical residues: x2 from 0 to 2^N, x3 from 0 to 2^N-2.

Top module: `rns_rev_conv_preoff`

## Requirements
- R1: While rst_ni is low, x_o reads 0.
- R2: A residue triple that is stable at rising edge t appears on x_o after rising edge t+1. A new triple is accepted on every edge.
- R3: For any integer X with 0 ≤ X < 2^K·(2^{2N}-1), driving x1_i = X mod 2^K, x2_i = X mod (2^N+1) and x3_i = X mod (2^N-1) yields x_o = X.
- R4: The top value of the plus-one channel, x2_i = 2^N (bit N set, bits N-1..0 clear), converts correctly.
- R5: x_o[K-1:0] always equals the x1_i of the same triple. The even channel gets no offset.
- R6: The upper 2N bits of x_o are never all ones, so a zero V is always reported as 0. The end points X = 0 and X = 2^K·(2^{2N}-1)-1 convert exactly.
- R7: Each channel offset adder returns a canonical residue: (x2 + (2^K·C1 mod (2^N+1))) mod (2^N+1) and (x3 + (2^K·C1 mod (2^N-1))) mod (2^N-1). Sums that reach the modulus wrap. For N=3 and K=5, both offsets equal 4.
- R8: With K = 2N, where the rotation by K is the identity and the inverted x1 fills the whole word, every triple still converts per R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x1_i | input | K | Residue mod 2^K |
| x2_i | input | N+1 | Residue mod 2^N+1 |
| x3_i | input | N | Residue mod 2^N-1 |
| x_o | output | K+2N | Reconstructed binary value |

## Verification
The bench builds two instances. The first uses N=3, K=5, which is small enough to stream all 2016 values of the dynamic range back to back. That covers x2 = 8, every wrap of both offset adders (both offsets are 4), and the V = 0 and V = 62 end points. The second uses N=4, K=8. Here K equals 2N, which removes the x1 padding and the rotation by K. It is driven with directed end points, x2 = 16, and several thousand values drawn from a fixed-seed generator, each checked against the integer that produced the residues.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

  function automatic logic [63:0] mul_mod(input logic [63:0] a, input logic [63:0] b,
                                          input logic [63:0] m);
    return (a * b) % m;
  endfunction

  function automatic logic [63:0] pow2_mod(input int unsigned e, input logic [63:0] m);
    logic [63:0] r;
    r = 64'd1 % m;
    for (int unsigned i = 0; i < e; i++) r = (r * 64'd2) % m;
    return r;
  endfunction

  // Global constant of the conversion sum, mod 2^(2n)-1
  function automatic logic [63:0] core_const(input int unsigned n, input int unsigned k);
    logic [63:0] mp, full, c_pad, k2, t2, pre, rinv;
    full  = 64'd1 << (2 * n);
    mp    = full - 64'd1;
    c_pad = (full - (64'd1 << k)) % mp;
    k2    = (full - (64'd1 << n)) % mp;
    t2    = mul_mod(64'd1 << (2 * n - 1), k2, mp);
    pre   = (c_pad + mp - t2) % mp;
    rinv  = pow2_mod((2 * n - (k % (2 * n))) % (2 * n), mp);
    return mul_mod(rinv, pre, mp);
  endfunction

  // Residue of 2^k * C1 in a channel of modulus m
  function automatic logic [63:0] chan_offset(input int unsigned n, input int unsigned k,
                                              input logic [63:0] m);
    return mul_mod(pow2_mod(k, m), core_const(n, k) % m, m);
  endfunction

endpackage

// File: rtl/rrc_const_add.sv
module rrc_const_add #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned MOD   = 9,
  parameter int unsigned OFF   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] sum_o
);
  localparam int unsigned SW = WIDTH + 1;

  logic [SW-1:0]    raw;
  logic [WIDTH-1:0] nxt, sum_q;

  assign raw = {1'b0, a_i} + SW'(OFF);
  assign nxt = WIDTH'((raw >= SW'(MOD)) ? raw - SW'(MOD) : raw);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= nxt;
  end

  assign sum_o = sum_q;

  a_r7_sum_canonical: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sum_q) < MOD);

  a_r7_sum_congruent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(a_i) < MOD) |=> (32'(sum_q) == (32'($past(a_i)) + OFF) % MOD));

endmodule

// File: rtl/rrc_csa3.sv
module rrc_csa3 #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  logic [W-1:0] cy;

  assign s_o = a_i ^ b_i ^ c_i;
  assign cy  = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  // carry out of the top bit re-enters at weight 1 (2^W == 1)
  assign c_o = {cy[W-2:0], cy[W-1]};

endmodule

// File: rtl/rrc_eac_add.sv
module rrc_eac_add #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  logic [W:0]   sum;
  logic [W-1:0] folded;

  assign sum    = {1'b0, a_i} + {1'b0, b_i};
  assign folded = sum[W-1:0] + W'(sum[W]);
  // all ones is the second code for zero
  assign s_o    = (&folded) ? '0 : folded;

endmodule

// File: rtl/rrc_core.sv
module rrc_core #(
  parameter int unsigned N = 3,
  parameter int unsigned K = 5
) (
  input  logic [K-1:0]   x1_i,
  input  logic [N:0]     x2_i,
  input  logic [N-1:0]   x3_i,
  output logic [2*N-1:0] v_o
);
  localparam int unsigned W  = 2 * N;
  localparam int unsigned RA = K % W;
  localparam int unsigned RB = (K + 1) % W;

  function automatic logic [W-1:0] rotr(input logic [W-1:0] v, input int unsigned r);
    return (v >> r) | (v << (W - r));
  endfunction

  logic [K-1:0]   x1_n;
  logic [N-1:0]   x2_lo;
  logic [W-1:0]   t1, t2, t3;
  logic [W-1:0]   op1, op2, op3;
  logic [W-1:0]   cs_s, cs_c;

  assign x1_n  = ~x1_i;
  assign x2_lo = x2_i[N-1:0];

  // -x1 with padding ones folded into the constant
  assign t1 = W'(x1_n);
  // -(2^N-1)*x2 variable part; low half forced high when x2 = 2^N
  assign t2 = {~x2_lo, x2_lo | {N{x2_i[N]}}};
  assign t3 = {x3_i, x3_i};

  assign op1 = rotr(t1, RA);
  assign op2 = rotr(t2, RB);
  assign op3 = rotr(t3, RB);

  rrc_csa3 #(.W(W)) u_csa (
    .a_i(op1), .b_i(op2), .c_i(op3), .s_o(cs_s), .c_o(cs_c)
  );

  rrc_eac_add #(.W(W)) u_fin (
    .a_i(cs_s), .b_i(cs_c), .s_o(v_o)
  );

endmodule

// File: rtl/rns_rev_conv_preoff.sv
module rns_rev_conv_preoff #(
  parameter int unsigned N = 3,
  parameter int unsigned K = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [K-1:0]     x1_i,
  input  logic [N:0]       x2_i,
  input  logic [N-1:0]     x3_i,
  output logic [K+2*N-1:0] x_o
);
  localparam int unsigned W    = 2 * N;
  localparam int unsigned XW   = K + W;
  localparam int unsigned M2   = (1 << N) + 1;
  localparam int unsigned M3   = (1 << N) - 1;
  localparam int unsigned OFF2 = 32'(rrc_pkg::chan_offset(N, K, 64'(M2)));
  localparam int unsigned OFF3 = 32'(rrc_pkg::chan_offset(N, K, 64'(M3)));

  logic [K-1:0]  x1_q;
  logic [N:0]    x2c;
  logic [N-1:0]  x3c;
  logic [W-1:0]  v;
  logic [XW-1:0] out_q;
  logic [1:0]    fill_q;

  rrc_const_add #(.WIDTH(N + 1), .MOD(M2), .OFF(OFF2)) u_off_p (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(x2_i), .sum_o(x2c)
  );

  rrc_const_add #(.WIDTH(N), .MOD(M3), .OFF(OFF3)) u_off_m (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(x3_i), .sum_o(x3c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) x1_q <= '0;
    else         x1_q <= x1_i;
  end

  rrc_core #(.N(N), .K(K)) u_core (
    .x1_i(x1_q), .x2_i(x2c), .x3_i(x3c), .v_o(v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= {v, x1_q};
  end

  assign x_o = out_q;

  // cycles since reset, for the two-deep history check only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             fill_q <= '0;
    else if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
  end

  a_r5_even_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == 2'd2) |-> (x_o[K-1:0] == $past(x1_i, 2)));

  a_r6_v_canonical: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_o[XW-1:K] != {W{1'b1}});

endmodule

// File: tb/rns_rev_conv_preoff_test.sv
`timescale 1ns/1ps
module rns_rev_conv_preoff_test;
  localparam int NA = 3, KA = 5;
  localparam int MA = (1 << KA) * ((1 << (2 * NA)) - 1);
  localparam int NB = 4, KB = 8;
  localparam int MB = (1 << KB) * ((1 << (2 * NB)) - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [KA-1:0]      x1a = '0;
  logic [NA:0]        x2a = '0;
  logic [NA-1:0]      x3a = '0;
  logic [KA+2*NA-1:0] xoa;
  logic [KB-1:0]      x1b = '0;
  logic [NB:0]        x2b = '0;
  logic [NB-1:0]      x3b = '0;
  logic [KB+2*NB-1:0] xob;

  int nchk = 0, nfail = 0;
  int pa0, pa1, cnta, pb0, pb1, cntb;
  string ta0, ta1, tb0, tb1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rns_rev_conv_preoff #(.N(NA), .K(KA)) uut (
    .clk_i(clk), .rst_ni(rst_n), .x1_i(x1a), .x2_i(x2a), .x3_i(x3a), .x_o(xoa)
  );

  rns_rev_conv_preoff #(.N(NB), .K(KB)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .x1_i(x1b), .x2_i(x2b), .x3_i(x3b), .x_o(xob)
  );

  task automatic chk(input int act, input int exp, input string tag);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  // streaming driver: output at this negedge belongs to the triple from two pushes ago
  task automatic push_a(input int xv, input string tag);
    @(negedge clk);
    if (cnta >= 2) begin
      chk(int'(xoa), pa1, ta1);
      chk(int'(xoa[KA-1:0]), pa1 % (1 << KA), "R5");
    end
    pa1 = pa0; ta1 = ta0; pa0 = xv; ta0 = tag;
    x1a = KA'(xv % (1 << KA));
    x2a = (NA+1)'(xv % ((1 << NA) + 1));
    x3a = NA'(xv % ((1 << NA) - 1));
    cnta++;
  endtask

  task automatic push_b(input int xv, input string tag);
    @(negedge clk);
    if (cntb >= 2) begin
      chk(int'(xob), pb1, tb1);
      chk(int'(xob[KB-1:0]), pb1 % (1 << KB), "R5");
    end
    pb1 = pb0; tb1 = tb0; pb0 = xv; tb0 = tag;
    x1b = KB'(xv % (1 << KB));
    x2b = (NB+1)'(xv % ((1 << NB) + 1));
    x3b = NB'(xv % ((1 << NB) - 1));
    cntb++;
  endtask

  function automatic string tag_a(input int xv);
    int r2 = xv % 9;
    int r3 = xv % 7;
    if (xv == 0 || xv == MA - 1) return "R6";
    if (r2 == 8) return "R4";
    if (r2 + 4 >= 9 || r3 + 4 >= 7) return "R7";
    return "R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h5EED_0042);
    cnta = 0; cntb = 0;
    // R1: reset holds outputs at zero despite live inputs
    x1a = 5'd7; x2a = 4'd3; x3a = 3'd2;
    x1b = 8'd9; x2b = 5'd4; x3b = 4'd5;
    repeat (3) begin
      @(negedge clk);
      chk(int'(xoa), 0, "R1");
      chk(int'(xob), 0, "R1");
    end
    rst_n = 1'b1;

    // R2: first triple after reset, then back-to-back streaming
    push_a(353, "R2");
    for (int x = 0; x < MA; x++) push_a(x, tag_a(x));
    push_a(MA - 1, "R6");
    push_a(0, "R6");
    push_a(0, "R3");
    push_a(0, "R3");

    // R8: K = 2N instance, directed corners then random values
    push_b(0, "R8");
    push_b(MB - 1, "R8");
    push_b(16, "R8");
    push_b(17 * 15 * 256 - 256, "R8");
    for (int i = 0; i < 5000; i++) push_b(int'($urandom % MB), "R8");
    push_b(0, "R8");
    push_b(0, "R8");

    summary();
  end

endmodule